// File: doc/BRIEF.md
# Victim Row Refresh Generator with Physical Row Mapping

When a DRAM row is flagged as an aggressor, this block works out which rows sit physically next to it. Each rank may scramble its row-address bits on the way to the cells, so the block first converts the low nine bits of the logical row address into a physical row index inside the 512-row subarray. It then takes the physical rows on either side of that index and converts each one back into a logical address. The resulting refresh requests leave the block one at a time over a valid/ready handshake. The row-address bits above the subarray field pass through unchanged.

Each rank has its own two-bit scheme field, which selects one of four translations: linear, mirrored, twisted, or mirrored-then-twisted. In conservative mode the configured scheme is ignored. The block then refreshes every neighbour that any of the four schemes implies, and requests each distinct row only once. A new aggressor is accepted only after the previous list of requests has drained.

Top module: `victim_refresh_gen`

## Requirements
- R1: Scheme code 0 (linear) uses the logical index as the physical index. The requests are logical row minus one, then logical row plus one.
- R2: Scheme code 1 (mirrored) keeps bits 0..2 and exchanges bits 3 and 4, 5 and 6, and 7 and 8. For example, aggressor 8 (physical 16) yields requests for 23, then 9.
- R3: Scheme code 2 (twisted) sets physical bit 1 to b1^b3 and physical bit 2 to b2^b3, and leaves all other bits unchanged.
- R4: Scheme code 3 applies the mirror first and then the twist to the mirrored value. The neighbours are converted back by undoing the twist and then the mirror.
- R5: The scheme in use is the field `rank_scheme[2*agg_rank +: 2]` of the aggressor's rank.
- R6: An aggressor at physical index 0 or 511 gets exactly one request, for its single in-subarray neighbour. No request ever crosses the subarray edge.
- R7: When `conservative` is 1, the candidates are taken for schemes 0, 1, 2 and 3 in that order, lower neighbour before upper for each scheme. A row that repeats an earlier candidate is dropped, so each distinct row is requested exactly once.
- R8: Bits above bit 8 of `req_row` equal the same bits of the accepted `agg_row`.
- R9: `agg_ready` is 1 only when no request is pending. `req_valid` rises in the cycle after an aggressor is accepted.
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_row` holds its value and `req_valid` stays high.
- R11: After reset, `req_valid` is 0 and `agg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agg_valid | input | 1 | An aggressor row is offered |
| agg_ready | output | 1 | The block can accept an aggressor |
| agg_row | input | ROW_W | Logical row address of the aggressor |
| agg_rank | input | RANK_W | Rank of the aggressor |
| rank_scheme | input | 2*RANKS | Two-bit mapping scheme for each rank |
| conservative | input | 1 | Refresh the union of neighbours over all schemes |
| req_valid | output | 1 | A refresh request is pending |
| req_ready | input | 1 | The consumer takes the request |
| req_row | output | ROW_W | Logical row address to refresh |

## Verification
An aggressor accepted at a clock edge raises `req_valid` and drops `agg_ready` by the following falling edge, where the bench samples both. After that, one request retires at each rising edge where `req_ready` is high. The bench changes `req_ready` only on falling edges and compares `req_row` on every falling edge against the next expected entry. It advances its pointer only when that request was handshaken, so a stalled request is compared again one cycle later. Once `req_valid` falls, the number of rows taken must equal the length of the expected list, and `agg_ready` must be back to 1 in that same sample.

// File: rtl/victim_refresh_gen.sv
module victim_refresh_gen #(
  parameter int ROW_W = 14,
  parameter int RANKS = 2,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int SUB_W = 9,
  localparam int NCAND = 8,
  localparam int IDX_W = $clog2(NCAND)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 agg_valid,
  output logic                 agg_ready,
  input  logic [ROW_W-1:0]     agg_row,
  input  logic [RANK_W-1:0]    agg_rank,
  input  logic [2*RANKS-1:0]   rank_scheme,
  input  logic                 conservative,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ROW_W-1:0]     req_row
);

  function automatic logic [SUB_W-1:0] mirror(input logic [SUB_W-1:0] x);
    return {x[7], x[8], x[5], x[6], x[3], x[4], x[2:0]};
  endfunction

  function automatic logic [SUB_W-1:0] twist(input logic [SUB_W-1:0] x);
    return {x[8:3], x[2] ^ x[3], x[1] ^ x[3], x[0]};
  endfunction

  function automatic logic [SUB_W-1:0] to_phys(input logic [1:0] s, input logic [SUB_W-1:0] x);
    case (s)
      2'd0:    return x;
      2'd1:    return mirror(x);
      2'd2:    return twist(x);
      default: return twist(mirror(x));
    endcase
  endfunction

  function automatic logic [SUB_W-1:0] to_logic(input logic [1:0] s, input logic [SUB_W-1:0] x);
    case (s)
      2'd0:    return x;
      2'd1:    return mirror(x);
      2'd2:    return twist(x);
      default: return mirror(twist(x));
    endcase
  endfunction

  logic [1:0]             sel_scheme;
  logic [SUB_W-1:0]       lrow;
  logic [SUB_W-1:0]       cand_row [NCAND];
  logic [NCAND-1:0]       cand_en, cand_keep;
  logic [NCAND-1:0]       pend;
  logic [SUB_W-1:0]       q_row [NCAND];
  logic [ROW_W-SUB_W-1:0] q_hi;
  logic [IDX_W-1:0]       idx;
  logic                   accept, retire;

  assign sel_scheme = rank_scheme[2*int'(agg_rank) +: 2];
  assign lrow       = agg_row[SUB_W-1:0];

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    localparam logic [1:0] S  = 2'(k / 2);
    localparam bit         UP = (k % 2) == 1;
    logic [SUB_W-1:0] p;
    assign p           = to_phys(S, lrow);
    assign cand_en[k]  = (conservative || sel_scheme == S) &&
                         (UP ? (p != {SUB_W{1'b1}}) : (p != '0));
    assign cand_row[k] = to_logic(S, UP ? p + 1'b1 : p - 1'b1);
  end

  always_comb begin
    for (int k = 0; k < NCAND; k++) begin
      cand_keep[k] = cand_en[k];
      for (int j = 0; j < k; j++)
        if (cand_en[j] && cand_row[j] == cand_row[k]) cand_keep[k] = 1'b0;
    end
  end

  always_comb begin
    idx = '0;
    for (int k = NCAND - 1; k >= 0; k--)
      if (pend[k]) idx = IDX_W'(k);
  end

  assign agg_ready = (pend == '0);
  assign req_valid = |pend;
  assign req_row   = {q_hi, q_row[idx]};
  assign accept    = agg_valid && agg_ready;
  assign retire    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      q_hi <= '0;
      for (int k = 0; k < NCAND; k++) q_row[k] <= '0;
    end else if (accept) begin
      pend  <= cand_keep;
      q_hi  <= agg_row[ROW_W-1:SUB_W];
      q_row <= cand_row;
    end else if (retire) begin
      pend[idx] <= 1'b0;
    end
  end

  assert_busy_blocks_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !agg_ready);
  assert_accept_starts_list_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> req_valid);
  assert_hold_when_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row)));
  assert_one_row_per_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> ($countones(pend) == $countones($past(pend)) - 1));

endmodule

// File: tb/test_victim_refresh_gen.sv
module test_victim_refresh_gen;
  localparam int ROW_W = 14;
  localparam int RANKS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic agg_valid = 1'b0;
  logic agg_ready;
  logic [ROW_W-1:0] agg_row = '0;
  logic [0:0] agg_rank = '0;
  logic [3:0] rank_scheme = '0;
  logic conservative = 1'b0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [ROW_W-1:0] req_row;

  always #5 clk = ~clk;

  victim_refresh_gen #(.ROW_W(ROW_W), .RANKS(RANKS)) i_victim_refresh_gen (
    .clk(clk), .rst_n(rst_n), .agg_valid(agg_valid), .agg_ready(agg_ready),
    .agg_row(agg_row), .agg_rank(agg_rank), .rank_scheme(rank_scheme),
    .conservative(conservative), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  logic [8:0] ord [4][512];
  logic [8:0] exp_list [8];
  int n_exp;

  function automatic logic [8:0] phys(input int s, input logic [8:0] x);
    logic [8:0] m;
    m = (s == 1 || s == 3) ? {x[7], x[8], x[5], x[6], x[3], x[4], x[2:0]} : x;
    if (s >= 2) m = {m[8:3], m[2] ^ m[3], m[1] ^ m[3], m[0]};
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic add_exp(input logic [8:0] r);
    for (int i = 0; i < n_exp; i++) if (exp_list[i] == r) return;
    exp_list[n_exp] = r;
    n_exp++;
  endtask

  task automatic run_event(input int r, input int l, input bit cons, input int hi, input string tag);
    int s, p, idx, iter;
    logic [ROW_W-1:0] held;
    bit rdy;
    s = int'(rank_scheme[2*r +: 2]);
    n_exp = 0;
    for (int t = 0; t < 4; t++) begin
      if (cons || t == s) begin
        p = int'(phys(t, 9'(l)));
        if (p != 0)   add_exp(ord[t][p-1]);
        if (p != 511) add_exp(ord[t][p+1]);
      end
    end
    @(negedge clk);
    agg_rank = 1'(r);
    agg_row = {5'(hi), 9'(l)};
    conservative = cons;
    agg_valid = 1'b1;
    chk(agg_ready === 1'b1, "R9 idle ready", 32'(agg_ready), 1);
    @(negedge clk);
    agg_valid = 1'b0;
    chk(req_valid === 1'b1 && agg_ready === 1'b0, "R9 busy after accept",
        {30'd0, req_valid, agg_ready}, 2);
    chk(req_row[ROW_W-1:9] == 5'(hi), "R8 upper bits", 32'(req_row[ROW_W-1:9]), 32'(hi));
    idx = 0;
    iter = 0;
    while (req_valid && iter < 40) begin
      rdy = ((iter + l) % 3) != 2;
      req_ready = rdy;
      if (idx < n_exp)
        chk(req_row == {5'(hi), exp_list[idx]}, tag, 32'(req_row), 32'({5'(hi), exp_list[idx]}));
      else
        chk(1'b0, tag, 32'(req_row), 32'hffff_ffff);
      held = req_row;
      @(negedge clk);
      if (!rdy) chk(req_valid === 1'b1 && req_row == held, "R10 stalled hold", 32'(req_row), 32'(held));
      else idx++;
      iter++;
    end
    req_ready = 1'b0;
    chk(idx == n_exp, (n_exp == 1) ? "R6 single edge request" : tag, 32'(idx), 32'(n_exp));
    chk(agg_ready === 1'b1, "R9 ready after drain", 32'(agg_ready), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    string tags [4];
    tags[0] = "R1 linear R5";
    tags[1] = "R2 mirrored R5";
    tags[2] = "R3 twisted R5";
    tags[3] = "R4 mirror twist R5";
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 512; l++) ord[s][phys(s, 9'(l))] = 9'(l);
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0 && agg_ready === 1'b1, "R11 reset state",
        {30'd0, req_valid, agg_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b0 && agg_ready === 1'b1, "R11 after release",
        {30'd0, req_valid, agg_ready}, 1);

    for (int s = 0; s < 4; s++) begin
      int r;
      r = s % 2;
      rank_scheme[2*r +: 2] = 2'(s);
      rank_scheme[2*(1-r) +: 2] = 2'(3 - s);
      for (int l = 0; l < 512; l++) run_event(r, l, 1'b0, (l * 7 + s) % 32, tags[s]);
    end

    rank_scheme = 4'b0110;
    run_event(1, 8, 1'b0, 3, "R2 example aggressor 8");
    chk(exp_list[0] == 9'd23 && exp_list[1] == 9'd9, "R2 example list",
        {14'd0, exp_list[0], exp_list[1]}, {14'd0, 9'd23, 9'd9});

    for (int l = 0; l < 512; l++) run_event(l % 2, l, 1'b1, (l * 5) % 32, "R7 conservative");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule